// File: doc/BRIEF.md
# Power-Aware Memory Operation Arbiter

This block sits in front of a four-bank non-volatile memory and decides, in a single clock cycle, which of the requests presented by several requesters may start. Every requester presents a request flag, an operation (read, program or erase) and a target bank. The arbiter tracks the operations already in flight: which banks are occupied and by which kind of operation. It then grants the largest set of new operations that can be added without breaking any constraint.

There are four constraints. A bank serves one operation at a time. The number of concurrent operations is capped. At most one program and at most one erase may be in flight. The summed power cost of everything in flight must stay within a budget that software can change. Requesters are visited in order of a programmable priority, with ties going to the lower index, and each one is admitted greedily if it still fits. A bank stays occupied from its grant until the bank returns a completion pulse.

A request that is not granted is not stored. The requester keeps it asserted until a grant is seen in the same cycle. It then drops the request or presents its next one.

Top module: `pwr_mem_arbiter`

## Requirements
- R1: `gnt_o` is a combinational function of the current inputs and tracked state, decided in the same cycle the request is seen; a grant is only ever given to a requester whose `req_i` bit is high in that cycle.
- R2: A bank holds at most one operation. A bank becomes busy at the clock edge that ends its grant cycle and stays busy until a `done_i` pulse for it. No grant targets a busy bank, and of several same-cycle requests to one idle bank at most one is granted.
- R3: The number of busy banks never exceeds `MAX_ACTIVE`; further requests wait even when idle banks remain.
- R4: At most one program operation (op code 1) is in flight at any time.
- R5: At most one erase operation (op code 2) is in flight at any time.
- R6: Costs are read 1, program 3, erase 4 (op codes 0, 1, 2). A grant is given only if the summed cost of all in-flight operations, including this one, is at most `budget_i`. Op code 3 is reserved and never granted, and it does not block its bank.
- R7: Candidates are visited from the highest `prio_i` field value to the lowest, with ties going to the lower requester index. A candidate that fails a constraint is skipped, and a later candidate that fits is still granted in the same cycle.
- R8: A `done_i` pulse for a busy bank makes it idle from the next cycle, so the bank cannot be re-granted in the pulse cycle. A pulse for an idle bank has no effect and does not stop a grant to that bank in the same cycle.
- R9: While `rst_ni` is low, `gnt_o` is all zero. After reset all banks are idle and the in-flight load is zero.
- R10: Lowering `budget_i` below the in-flight load never cancels in-flight operations. New grants resume once completions bring the load down far enough for the new operation to fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_REQ | Request flag per requester |
| op_i | input | 2*N_REQ | Operation per requester: 0 read, 1 program, 2 erase, 3 reserved |
| bank_i | input | BANK_W*N_REQ | Target bank per requester |
| prio_i | input | PRIO_W*N_REQ | Priority per requester, larger value served first |
| budget_i | input | PWR_W | Available power in cost units |
| done_i | input | N_BANK | Completion pulse per bank |
| gnt_o | output | N_REQ | Grant per requester, valid in the request cycle |

## Verification
The bench builds the arbiter with six requesters on the four banks and `MAX_ACTIVE` set to 3. This leaves more requesters than banks, so same-bank contention occurs, and the concurrency cap binds while a bank is still idle, which the default cap of 4 on four banks could never show. The budget register is 5 bits wide and is swept from below a single erase up to above the worst-case load, so it can run both tighter and looser than the type limits. Directed sequences cover each constraint on its own. A long pseudo-random phase then varies priorities, budgets, withdrawals, reserved codes and completion pulses on idle banks, and a behavioural ranking model checks every cycle.

// File: rtl/pma_pkg.sv
package pma_pkg;
  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/pma_bank_state.sv
module pma_bank_state
  import pma_pkg::*;
#(
  parameter int N_BANK = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_BANK-1:0]      set_i,
  input  logic [N_BANK*OP_W-1:0] set_op_i,
  input  logic [N_BANK-1:0]      done_i,
  output logic [N_BANK-1:0]      busy_o,
  output logic [N_BANK*OP_W-1:0] op_o
);

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic            busy_q;
    logic [OP_W-1:0] op_q;

    // a grant only lands on an idle bank, so set outranks done
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q <= 1'b0;
        op_q   <= OP_READ;
      end else if (set_i[b]) begin
        busy_q <= 1'b1;
        op_q   <= set_op_i[b*OP_W +: OP_W];
      end else if (done_i[b]) begin
        busy_q <= 1'b0;
      end
    end

    assign busy_o[b]              = busy_q;
    assign op_o[b*OP_W +: OP_W]   = op_q;
  end

endmodule

// File: rtl/pma_load_sum.sv
module pma_load_sum
  import pma_pkg::*;
#(
  parameter int N_BANK     = 4,
  parameter int LOAD_W     = 5,
  parameter int CNT_W      = 3,
  parameter int COST_READ  = 1,
  parameter int COST_PROG  = 3,
  parameter int COST_ERASE = 4
) (
  input  logic [N_BANK-1:0]      busy_i,
  input  logic [N_BANK*OP_W-1:0] op_i,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   prog_o,
  output logic                   erase_o,
  output logic [LOAD_W-1:0]      load_o
);

  localparam logic [LOAD_W-1:0] C_RD = LOAD_W'(COST_READ);
  localparam logic [LOAD_W-1:0] C_PG = LOAD_W'(COST_PROG);
  localparam logic [LOAD_W-1:0] C_ER = LOAD_W'(COST_ERASE);

  logic [LOAD_W-1:0] cost_b [N_BANK];
  logic [N_BANK-1:0] is_prog;
  logic [N_BANK-1:0] is_erase;

  for (genvar b = 0; b < N_BANK; b++) begin : g_cost
    logic [OP_W-1:0] op_b;
    assign op_b        = op_i[b*OP_W +: OP_W];
    assign is_prog[b]  = busy_i[b] && (op_b == OP_PROG);
    assign is_erase[b] = busy_i[b] && (op_b == OP_ERASE);
    always_comb begin
      cost_b[b] = '0;
      if (busy_i[b]) begin
        unique case (op_b)
          OP_PROG:  cost_b[b] = C_PG;
          OP_ERASE: cost_b[b] = C_ER;
          OP_READ:  cost_b[b] = C_RD;
          default:  cost_b[b] = '0;
        endcase
      end
    end
  end

  always_comb begin
    cnt_o  = '0;
    load_o = '0;
    for (int b = 0; b < N_BANK; b++) begin
      cnt_o  = cnt_o + CNT_W'(busy_i[b]);
      load_o = load_o + cost_b[b];
    end
  end

  assign prog_o  = |is_prog;
  assign erase_o = |is_erase;

endmodule

// File: rtl/pma_pick.sv
module pma_pick
  import pma_pkg::*;
#(
  parameter int N_REQ      = 4,
  parameter int N_BANK     = 4,
  parameter int BANK_W     = 2,
  parameter int PRIO_W     = 2,
  parameter int LOAD_W     = 5,
  parameter int CNT_W      = 3,
  parameter int MAX_ACTIVE = 4,
  parameter int COST_READ  = 1,
  parameter int COST_PROG  = 3,
  parameter int COST_ERASE = 4
) (
  input  logic [N_REQ-1:0]        req_i,
  input  logic [N_REQ*OP_W-1:0]   op_i,
  input  logic [N_REQ*BANK_W-1:0] bank_i,
  input  logic [N_REQ*PRIO_W-1:0] prio_i,
  input  logic [LOAD_W-1:0]       budget_i,
  input  logic [N_BANK-1:0]       busy_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    prog_i,
  input  logic                    erase_i,
  input  logic [LOAD_W-1:0]       load_i,
  output logic [N_REQ-1:0]        gnt_o,
  output logic [N_BANK-1:0]       set_o,
  output logic [N_BANK*OP_W-1:0]  set_op_o
);

  localparam int N_PRIO = 1 << PRIO_W;

  logic [OP_W-1:0]   op_a   [N_REQ];
  logic [BANK_W-1:0] bank_a [N_REQ];
  logic [PRIO_W-1:0] prio_a [N_REQ];

  for (genvar r = 0; r < N_REQ; r++) begin : g_unpack
    assign op_a[r]   = op_i[r*OP_W +: OP_W];
    assign bank_a[r] = bank_i[r*BANK_W +: BANK_W];
    assign prio_a[r] = prio_i[r*PRIO_W +: PRIO_W];
  end

  function automatic logic [LOAD_W-1:0] op_cost(input logic [OP_W-1:0] op);
    unique case (op)
      OP_PROG:  op_cost = LOAD_W'(COST_PROG);
      OP_ERASE: op_cost = LOAD_W'(COST_ERASE);
      OP_READ:  op_cost = LOAD_W'(COST_READ);
      default:  op_cost = '0;
    endcase
  endfunction

  logic [N_BANK-1:0] busy_v;
  logic [CNT_W-1:0]  cnt_v;
  logic              prog_v;
  logic              erase_v;
  logic [LOAD_W:0]   load_v;
  logic [LOAD_W:0]   need_v;
  logic              fit_v;

  // greedy walk: priority level outer, requester index inner
  always_comb begin
    gnt_o    = '0;
    set_o    = '0;
    set_op_o = '0;
    busy_v   = busy_i;
    cnt_v    = cnt_i;
    prog_v   = prog_i;
    erase_v  = erase_i;
    load_v   = {1'b0, load_i};
    need_v   = '0;
    fit_v    = 1'b0;
    for (int p = N_PRIO - 1; p >= 0; p--) begin
      for (int r = 0; r < N_REQ; r++) begin
        need_v = load_v + {1'b0, op_cost(op_a[r])};
        fit_v  = req_i[r]
              && (prio_a[r] == PRIO_W'(p))
              && (op_a[r] != OP_RSVD)
              && (int'(bank_a[r]) < N_BANK)
              && !busy_v[bank_a[r]]
              && (int'(cnt_v) < MAX_ACTIVE)
              && !((op_a[r] == OP_PROG) && prog_v)
              && !((op_a[r] == OP_ERASE) && erase_v)
              && (need_v <= {1'b0, budget_i});
        if (fit_v) begin
          gnt_o[r]                            = 1'b1;
          busy_v[bank_a[r]]                   = 1'b1;
          set_o[bank_a[r]]                    = 1'b1;
          set_op_o[bank_a[r]*OP_W +: OP_W]    = op_a[r];
          cnt_v                               = cnt_v + CNT_W'(1);
          prog_v                              = prog_v  || (op_a[r] == OP_PROG);
          erase_v                             = erase_v || (op_a[r] == OP_ERASE);
          load_v                              = need_v;
        end
      end
    end
  end

endmodule

// File: rtl/pwr_mem_arbiter.sv
module pwr_mem_arbiter
  import pma_pkg::*;
#(
  parameter int N_REQ      = 4,
  parameter int N_BANK     = 4,
  parameter int PRIO_W     = 2,
  parameter int PWR_W      = 5,
  parameter int MAX_ACTIVE = 4,
  parameter int COST_READ  = 1,
  parameter int COST_PROG  = 3,
  parameter int COST_ERASE = 4,
  localparam int BANK_W    = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        req_i,
  input  logic [N_REQ*2-1:0]      op_i,
  input  logic [N_REQ*BANK_W-1:0] bank_i,
  input  logic [N_REQ*PRIO_W-1:0] prio_i,
  input  logic [PWR_W-1:0]        budget_i,
  input  logic [N_BANK-1:0]       done_i,
  output logic [N_REQ-1:0]        gnt_o
);

  localparam int CNT_W = $clog2(N_BANK + 1);

  logic [N_BANK-1:0]      bank_busy;
  logic [N_BANK*OP_W-1:0] bank_op;
  logic [N_BANK-1:0]      bank_set;
  logic [N_BANK*OP_W-1:0] bank_set_op;
  logic [CNT_W-1:0]       act_cnt;
  logic                   prog_act;
  logic                   erase_act;
  logic [PWR_W-1:0]       act_load;
  logic [N_REQ-1:0]       gnt_raw;

  pma_bank_state #(
    .N_BANK (N_BANK)
  ) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (bank_set),
    .set_op_i (bank_set_op),
    .done_i   (done_i),
    .busy_o   (bank_busy),
    .op_o     (bank_op)
  );

  pma_load_sum #(
    .N_BANK     (N_BANK),
    .LOAD_W     (PWR_W),
    .CNT_W      (CNT_W),
    .COST_READ  (COST_READ),
    .COST_PROG  (COST_PROG),
    .COST_ERASE (COST_ERASE)
  ) u_load (
    .busy_i  (bank_busy),
    .op_i    (bank_op),
    .cnt_o   (act_cnt),
    .prog_o  (prog_act),
    .erase_o (erase_act),
    .load_o  (act_load)
  );

  pma_pick #(
    .N_REQ      (N_REQ),
    .N_BANK     (N_BANK),
    .BANK_W     (BANK_W),
    .PRIO_W     (PRIO_W),
    .LOAD_W     (PWR_W),
    .CNT_W      (CNT_W),
    .MAX_ACTIVE (MAX_ACTIVE),
    .COST_READ  (COST_READ),
    .COST_PROG  (COST_PROG),
    .COST_ERASE (COST_ERASE)
  ) u_pick (
    .req_i    (req_i),
    .op_i     (op_i),
    .bank_i   (bank_i),
    .prio_i   (prio_i),
    .budget_i (budget_i),
    .busy_i   (bank_busy),
    .cnt_i    (act_cnt),
    .prog_i   (prog_act),
    .erase_i  (erase_act),
    .load_i   (act_load),
    .gnt_o    (gnt_raw),
    .set_o    (bank_set),
    .set_op_o (bank_set_op)
  );

  assign gnt_o = rst_ni ? gnt_raw : '0;

endmodule

// File: rtl/pma_chk.sv
module pma_chk
  import pma_pkg::*;
#(
  parameter int N_REQ      = 4,
  parameter int N_BANK     = 4,
  parameter int BANK_W     = 2,
  parameter int PWR_W      = 5,
  parameter int MAX_ACTIVE = 4,
  parameter int COST_READ  = 1,
  parameter int COST_PROG  = 3,
  parameter int COST_ERASE = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_REQ-1:0]        req_i,
  input logic [N_REQ*2-1:0]      op_i,
  input logic [N_REQ*BANK_W-1:0] bank_i,
  input logic [PWR_W-1:0]        budget_i,
  input logic [N_BANK-1:0]       done_i,
  input logic [N_REQ-1:0]        gnt_o,
  input logic [N_BANK-1:0]       busy_i,
  input logic [N_BANK*OP_W-1:0]  bank_op_i
);

  logic [N_BANK-1:0] prog_live;
  logic [N_BANK-1:0] erase_live;
  int                chk_load;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bk
    logic [N_REQ-1:0] hit;
    assign prog_live[b]  = busy_i[b] && (bank_op_i[b*OP_W +: OP_W] == OP_PROG);
    assign erase_live[b] = busy_i[b] && (bank_op_i[b*OP_W +: OP_W] == OP_ERASE);
    for (genvar r = 0; r < N_REQ; r++) begin : g_hit
      assign hit[r] = gnt_o[r] && (int'(bank_i[r*BANK_W +: BANK_W]) == b);
    end

    p_one_per_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hit) <= 1);
    p_idle_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|hit) |-> !busy_i[b]);
    p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i[b] && !done_i[b]) |=> busy_i[b]);
    p_done_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i[b] && done_i[b]) |=> !busy_i[b]);
  end

  for (genvar r = 0; r < N_REQ; r++) begin : g_rq
    p_no_rsvd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[r*2 +: 2] == 2'd3) |-> !gnt_o[r]);
  end

  always_comb begin
    chk_load = 0;
    for (int b = 0; b < N_BANK; b++) begin
      if (prog_live[b])       chk_load = chk_load + COST_PROG;
      else if (erase_live[b]) chk_load = chk_load + COST_ERASE;
      else if (busy_i[b])     chk_load = chk_load + COST_READ;
    end
  end

  p_gnt_has_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  p_active_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(busy_i) <= MAX_ACTIVE);
  p_one_prog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prog_live));
  p_one_erase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(erase_live));
  p_budget_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> (chk_load <= int'($past(budget_i))));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_quiet_r9: assert (gnt_o == '0);
    end
  end

endmodule

bind pwr_mem_arbiter pma_chk #(
  .N_REQ      (N_REQ),
  .N_BANK     (N_BANK),
  .BANK_W     (BANK_W),
  .PWR_W      (PWR_W),
  .MAX_ACTIVE (MAX_ACTIVE),
  .COST_READ  (COST_READ),
  .COST_PROG  (COST_PROG),
  .COST_ERASE (COST_ERASE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .op_i      (op_i),
  .bank_i    (bank_i),
  .budget_i  (budget_i),
  .done_i    (done_i),
  .gnt_o     (gnt_o),
  .busy_i    (bank_busy),
  .bank_op_i (bank_op)
);

// File: tb/pwr_mem_arbiter_tb_top.sv
`timescale 1ns/1ps
module pwr_mem_arbiter_tb_top;
  localparam int NR  = 6;
  localparam int NB  = 4;
  localparam int BW  = 2;
  localparam int PW  = 2;
  localparam int WW  = 5;
  localparam int CAP = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NR-1:0]   req_i = '0;
  logic [NR*2-1:0] op_i = '0;
  logic [NR*BW-1:0] bank_i = '0;
  logic [NR*PW-1:0] prio_i = '0;
  logic [WW-1:0]   budget_i = '0;
  logic [NB-1:0]   done_i = '0;
  logic [NR-1:0]   gnt_o;

  int errors = 0;
  int checks = 0;
  logic [NR-1:0] cur_gnt;
  int m_busy [NB];
  int m_op   [NB];

  always #5 clk_i = ~clk_i;

  pwr_mem_arbiter #(
    .N_REQ(NR), .N_BANK(NB), .PRIO_W(PW), .PWR_W(WW), .MAX_ACTIVE(CAP)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i),
    .bank_i(bank_i), .prio_i(prio_i), .budget_i(budget_i),
    .done_i(done_i), .gnt_o(gnt_o)
  );

  function automatic int cost_of(int op);
    if (op == 0) return 1;
    if (op == 1) return 3;
    if (op == 2) return 4;
    return 0;
  endfunction

  // rank every requester by (prio, -index), then admit in that order
  function automatic logic [NR-1:0] model_gnt();
    logic [NR-1:0] g = '0;
    int order [$];
    int used [NB];
    int n = 0, pg = 0, er = 0, ld = 0;
    for (int b = 0; b < NB; b++) begin
      used[b] = m_busy[b];
      if (m_busy[b] != 0) begin
        n++; ld += cost_of(m_op[b]);
        if (m_op[b] == 1) pg++;
        if (m_op[b] == 2) er++;
      end
    end
    for (int r = 0; r < NR; r++) begin
      int key = int'(prio_i[r*PW +: PW]) * NR + (NR - 1 - r);
      int pos = 0;
      while (pos < order.size() &&
             (int'(prio_i[order[pos]*PW +: PW]) * NR + (NR - 1 - order[pos])) > key) pos++;
      order.insert(pos, r);
    end
    foreach (order[k]) begin
      int r  = order[k];
      int op = int'(op_i[r*2 +: 2]);
      int bk = int'(bank_i[r*BW +: BW]);
      if (req_i[r] && op != 3 && used[bk] == 0 && n < CAP &&
          !(op == 1 && pg > 0) && !(op == 2 && er > 0) &&
          ld + cost_of(op) <= int'(budget_i)) begin
        g[r] = 1'b1; used[bk] = 1; n++; ld += cost_of(op);
        if (op == 1) pg++;
        if (op == 2) er++;
      end
    end
    return g;
  endfunction

  task automatic tick(input string tag);
    logic [NR-1:0] exp;
    @(negedge clk_i);
    cur_gnt = gnt_o;
    if (!rst_ni) exp = '0;
    else exp = model_gnt();
    checks++;
    if (cur_gnt !== exp) begin
      errors++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, cur_gnt, exp);
    end
    if (rst_ni) begin
      for (int b = 0; b < NB; b++) if (done_i[b]) m_busy[b] = 0;
      for (int r = 0; r < NR; r++) if (exp[r]) begin
        m_busy[int'(bank_i[r*BW +: BW])] = 1;
        m_op[int'(bank_i[r*BW +: BW])]   = int'(op_i[r*2 +: 2]);
      end
    end
    @(posedge clk_i);
    #1;
  endtask

  task automatic expect_gnt(input string tag, input logic [NR-1:0] exp);
    checks++;
    if (cur_gnt !== exp) begin
      errors++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, cur_gnt, exp);
    end
  endtask

  task automatic put(input int r, input int op, input int bk, input int pr);
    req_i[r] = 1'b1;
    op_i[r*2 +: 2]    = 2'(op);
    bank_i[r*BW +: BW] = BW'(bk);
    prio_i[r*PW +: PW] = PW'(pr);
  endtask

  task automatic finish_all();
    req_i  = '0;
    done_i = '1;
    tick("R8 drain");
    done_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_busy[b] = 0; m_op[b] = 0; end
    @(posedge clk_i); #1;
    // R9: grants held low in reset even with requests present
    put(0, 0, 0, 3); put(1, 0, 1, 2);
    budget_i = 5'd31;
    tick("R9 reset");
    expect_gnt("R9 reset quiet", '0);
    rst_ni = 1'b1;
    req_i = '0;
    tick("R9 idle after reset");

    // R6/R7: budget 5 -> erase(4) then read(1), program skipped
    budget_i = 5'd5;
    put(0, 2, 0, 3); put(1, 1, 1, 2); put(2, 0, 2, 1);
    tick("R6 budget greedy");
    expect_gnt("R7 skip then admit", 6'b000101);
    req_i[0] = 1'b0; req_i[2] = 1'b0;
    tick("R6 over budget");
    expect_gnt("R6 program waits", '0);
    done_i[0] = 1'b1;
    tick("R8 pulse cycle");
    expect_gnt("R8 not freed yet", '0);
    done_i = '0;
    tick("R8 freed");
    expect_gnt("R8 program after done", 6'b000010);
    req_i = '0;
    finish_all();

    // R4/R5: one program and one erase at a time
    budget_i = 5'd31;
    put(0, 2, 0, 1); put(3, 2, 3, 2); put(1, 1, 1, 0); put(4, 1, 2, 3);
    tick("R4 R5 first pick");
    expect_gnt("R5 one erase", 6'b011000);
    req_i[3] = 1'b0; req_i[4] = 1'b0;
    tick("R4 hold");
    expect_gnt("R4 second program waits", '0);
    done_i[2] = 1'b1; done_i[3] = 1'b1;
    tick("R5 pulse");
    done_i = '0;
    tick("R4 R5 release");
    expect_gnt("R5 erase and program resume", 6'b000011);
    finish_all();

    // R2/R7: same bank contention and index tie
    put(2, 0, 3, 2); put(5, 0, 3, 2); put(1, 0, 3, 1);
    tick("R2 contention");
    expect_gnt("R7 tie lower index", 6'b000100);
    req_i[2] = 1'b0;
    tick("R2 busy bank");
    expect_gnt("R2 busy bank blocked", '0);
    done_i[3] = 1'b1; tick("R2 pulse"); done_i = '0;
    tick("R7 next");
    expect_gnt("R7 higher prio first", 6'b100000);
    req_i[5] = 1'b0;
    done_i[3] = 1'b1; tick("R2 pulse2"); done_i = '0;
    tick("R7 last");
    expect_gnt("R7 lowest prio served", 6'b000010);
    finish_all();

    // R3: cap of 3 with a bank still idle
    put(0, 0, 0, 0); put(1, 0, 1, 0); put(2, 0, 2, 0); put(3, 0, 3, 0);
    tick("R3 cap");
    expect_gnt("R3 three admitted", 6'b000111);
    req_i[2:0] = '0;
    tick("R3 waits");
    expect_gnt("R3 fourth waits", '0);
    done_i[1] = 1'b1; tick("R3 pulse"); done_i = '0;
    tick("R3 slot");
    expect_gnt("R3 fourth admitted", 6'b001000);
    finish_all();

    // R6: reserved op is never granted and leaves bank free
    put(0, 3, 0, 3); put(1, 0, 0, 0);
    tick("R6 reserved");
    expect_gnt("R6 reserved skipped", 6'b000010);
    finish_all();

    // R10: lowering budget does not cancel work
    budget_i = 5'd10;
    put(0, 2, 0, 3); put(1, 1, 1, 2);
    tick("R10 setup");
    expect_gnt("R10 both admitted", 6'b000011);
    req_i = '0;
    budget_i = 5'd2;
    put(2, 0, 0, 3);
    tick("R10 low budget");
    expect_gnt("R10 busy kept", '0);
    done_i[0] = 1'b1; tick("R10 pulse"); done_i = '0;
    tick("R10 load 3");
    expect_gnt("R10 still over budget", '0);
    done_i[1] = 1'b1; tick("R10 pulse2"); done_i = '0;
    tick("R10 resume");
    expect_gnt("R10 read resumes", 6'b000100);
    finish_all();

    // R1: fields valid but request low
    budget_i = 5'd31;
    put(0, 1, 1, 3); req_i[0] = 1'b0;
    tick("R1 no request");
    expect_gnt("R1 no grant without request", '0);

    // R8: done on idle bank ignored
    put(0, 0, 2, 3); done_i[2] = 1'b1;
    tick("R8 idle pulse");
    expect_gnt("R8 idle pulse no effect", 6'b000001);
    done_i = '0; req_i = '0;
    put(1, 0, 2, 3);
    tick("R8 bank taken");
    expect_gnt("R8 bank held", '0);
    finish_all();

    // random phase, every cycle against the model (R1..R10 mix)
    for (int c = 0; c < 4000; c++) begin
      if (c % 150 == 0) budget_i = WW'(2 + $urandom % 18);
      if (c % 97 == 0) prio_i = NR*PW'($urandom);
      for (int r = 0; r < NR; r++) begin
        if (req_i[r] && $urandom % 40 == 0) req_i[r] = 1'b0;
        else if (!req_i[r] && $urandom % 3 == 0)
          put(r, (($urandom % 16) == 0) ? 3 : int'($urandom % 3),
              int'($urandom % NB), int'(prio_i[r*PW +: PW]));
      end
      for (int b = 0; b < NB; b++) done_i[b] = ($urandom % 5 == 0);
      tick("R7 random model");
      req_i = req_i & ~cur_gnt;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule